// File: doc/BRIEF.md
# PLL Factor Search Engine

This block chooses a divider `m` and a multiplier `n` for a clock synthesiser so that the output, `n × reference / m`, lands as close as possible below a requested pixel clock. A start pulse passes in a reference frequency and a target frequency, both in kHz. Two search engines then run in lockstep. One searches against the reference as given. The other searches against twice the reference. Each engine evaluates one (m, n) pair per clock cycle and keeps the pair whose truncated result is closest below the target. A candidate that equals the target exactly is not accepted.

When both searches are finished, a selection stage compares them. It takes the doubled-reference result only if that result reaches a strictly higher frequency. It then reports the factors, the achieved frequency, a flag for the doubled source, the divider field value `m − 1`, and a found flag. The results stay on the outputs until the next accepted start. The block does not program the synthesiser or the clock mux; that is left to the logic that uses it.

Top module: `pll_factor_search`

## Requirements
- R1: After reset, `busy`, `done`, `found` and `dbl_sel` are 0, and `m_out`, `n_out`, `freq_khz` and `div_field` are 0.
- R2: Each search visits `m` from 1 to 15 in the outer loop and `n` from 9 to 127 in the inner loop, both ascending. The candidate is floor(n × ref / m). A candidate is taken when 0 < target − candidate < best difference so far. On a tie, the pair visited first is kept.
- R3: A candidate equal to the target is never taken, so a reported `freq_khz` is always strictly below the target.
- R4: The best difference starts at 1,000,000 kHz, so a candidate 1,000,000 kHz or more below the target is never taken.
- R5: The second search uses twice `ref_khz`. Its result is chosen, with `dbl_sel` = 1, only when its frequency is strictly greater than that of the base search. Otherwise the base result is reported with `dbl_sel` = 0.
- R6: If neither search takes any candidate, then `found` = 0 and `m_out`, `n_out`, `freq_khz`, `div_field` and `dbl_sel` are all 0.
- R7: When `found` = 1, `div_field` equals `m_out` − 1.
- R8: Call the rising edge that samples `start` high while idle edge 1. From the cycle after that edge, `busy` is 1. `done` is a single-cycle pulse that rises, with `busy` falling, after edge 1786 (one edge plus 15 × 119 evaluation edges).
- R9: A `start` pulse while `busy` = 1 is ignored. The running search keeps the target it started with, and its done timing does not change.
- R10: The results are held on the outputs after `done` until the next accepted start, whatever the inputs do in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a search when idle |
| ref_khz | input | 13 | Base reference frequency, kHz |
| target_khz | input | 22 | Requested frequency, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A pair was found |
| dbl_sel | output | 1 | Chosen pair uses the doubled reference |
| m_out | output | 4 | Chosen divider (0 if none) |
| n_out | output | 7 | Chosen multiplier (0 if none) |
| freq_khz | output | 22 | Achieved frequency, kHz |
| div_field | output | 4 | Divider field value, m − 1 (0 if none) |

## Verification
Every result comes out together with `done`, 1786 rising edges after the edge that accepts `start`. `busy` must be high from the first falling edge after acceptance. The bench counts rising edges from the start edge and samples on falling edges. It checks that `done` is low through edge 1785 and high after edge 1786, then reads every result field in that same half cycle. It compares them with a model of the requirements. The hold check and the ignored-start check sample several cycles after the stimulus, and the ignored-start check repeats the cycle count.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    localparam int unsigned DIV_MIN   = 1;
    localparam int unsigned DIV_MAX   = 15;
    localparam int unsigned MUL_MIN   = 9;
    localparam int unsigned MUL_MAX   = 127;
    localparam int unsigned GAP_LIMIT = 1000000;
    localparam int unsigned NUM_SRC   = 2;   // base reference and doubled reference
endpackage

// File: rtl/pll_search_core.sv
module pll_search_core #(
    parameter int unsigned REF_W     = 14,
    parameter int unsigned FREQ_W    = 22,
    parameter int unsigned M_W       = 4,
    parameter int unsigned N_W       = 7,
    parameter int unsigned M_MIN     = 1,
    parameter int unsigned M_MAX     = 15,
    parameter int unsigned N_MIN     = 9,
    parameter int unsigned N_MAX     = 127,
    parameter int unsigned BEST_INIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic [FREQ_W-1:0] target_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [M_W-1:0]    m_o,
    output logic [N_W-1:0]    n_o,
    output logic [FREQ_W-1:0] f_o
);
    localparam int unsigned EW = FREQ_W + REF_W + N_W;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [M_W-1:0]    m;
        logic [N_W-1:0]    n;
        logic [FREQ_W-1:0] best;
        logic [M_W-1:0]    bm;
        logic [N_W-1:0]    bn;
        logic [FREQ_W-1:0] bf;
        logic [REF_W-1:0]  refv;
        logic [FREQ_W-1:0] tgt;
        logic [M_W-1:0]    rm;
        logic [N_W-1:0]    rn;
        logic [FREQ_W-1:0] rf;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [EW-1:0] cand_d, tgt_d, gap_d;

    always_comb begin
        st_d   = st_q;
        st_d.done = 1'b0;
        tgt_d  = EW'(st_q.tgt);
        cand_d = (EW'(st_q.n) * EW'(st_q.refv)) / EW'(st_q.m);
        gap_d  = tgt_d - cand_d;
        if (!st_q.busy) begin
            if (go_i) begin
                st_d.busy = 1'b1;
                st_d.m    = M_W'(M_MIN);
                st_d.n    = N_W'(N_MIN);
                st_d.best = FREQ_W'(BEST_INIT);
                st_d.bm   = '0;
                st_d.bn   = '0;
                st_d.bf   = '0;
                st_d.refv = ref_i;
                st_d.tgt  = target_i;
            end
        end else begin
            if ((cand_d < tgt_d) && (gap_d < EW'(st_q.best))) begin
                st_d.best = gap_d[FREQ_W-1:0];
                st_d.bm   = st_q.m;
                st_d.bn   = st_q.n;
                st_d.bf   = cand_d[FREQ_W-1:0];
            end
            if (st_q.n == N_W'(N_MAX)) begin
                st_d.n = N_W'(N_MIN);
                if (st_q.m == M_W'(M_MAX)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.rm   = st_d.bm;
                    st_d.rn   = st_d.bn;
                    st_d.rf   = st_d.bf;
                end else begin
                    st_d.m = st_q.m + 1'b1;
                end
            end else begin
                st_d.n = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign m_o    = st_q.rm;
    assign n_o    = st_q.rn;
    assign f_o    = st_q.rf;
endmodule

// File: rtl/pll_pick.sv
module pll_pick #(
    parameter int unsigned FREQ_W = 22,
    parameter int unsigned M_W    = 4,
    parameter int unsigned N_W    = 7
) (
    input  logic [M_W-1:0]    m_base_i,
    input  logic [N_W-1:0]    n_base_i,
    input  logic [FREQ_W-1:0] f_base_i,
    input  logic [M_W-1:0]    m_dbl_i,
    input  logic [N_W-1:0]    n_dbl_i,
    input  logic [FREQ_W-1:0] f_dbl_i,
    output logic              dbl_o,
    output logic              found_o,
    output logic [M_W-1:0]    m_o,
    output logic [N_W-1:0]    n_o,
    output logic [FREQ_W-1:0] f_o,
    output logic [M_W-1:0]    div_o
);
    always_comb begin
        dbl_o   = (f_dbl_i > f_base_i);
        m_o     = dbl_o ? m_dbl_i : m_base_i;
        n_o     = dbl_o ? n_dbl_i : n_base_i;
        f_o     = dbl_o ? f_dbl_i : f_base_i;
        found_o = (m_o != '0);
        div_o   = found_o ? (m_o - 1'b1) : '0;
    end
endmodule

// File: rtl/pll_factor_search.sv
module pll_factor_search
    import pll_search_pkg::*;
#(
    parameter int unsigned REF_W  = 13,
    parameter int unsigned FREQ_W = 22,
    parameter int unsigned M_W    = 4,
    parameter int unsigned N_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REF_W-1:0]  ref_khz,
    input  logic [FREQ_W-1:0] target_khz,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              dbl_sel,
    output logic [M_W-1:0]    m_out,
    output logic [N_W-1:0]    n_out,
    output logic [FREQ_W-1:0] freq_khz,
    output logic [M_W-1:0]    div_field
);
    localparam int unsigned CREF_W = REF_W + 1;

    logic [NUM_SRC-1:0]   busy_v, done_v;
    logic [M_W-1:0]       m_v [NUM_SRC];
    logic [N_W-1:0]       n_v [NUM_SRC];
    logic [FREQ_W-1:0]    f_v [NUM_SRC];
    logic                 go;

    assign go = start & ~busy_v[0];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [CREF_W-1:0] src_ref;
        assign src_ref = CREF_W'(ref_khz) << g;
        pll_search_core #(
            .REF_W(CREF_W), .FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W),
            .M_MIN(DIV_MIN), .M_MAX(DIV_MAX), .N_MIN(MUL_MIN), .N_MAX(MUL_MAX),
            .BEST_INIT(GAP_LIMIT)
        ) u_core (
            .clk(clk), .rst_n(rst_n), .go_i(go), .ref_i(src_ref),
            .target_i(target_khz), .busy_o(busy_v[g]), .done_o(done_v[g]),
            .m_o(m_v[g]), .n_o(n_v[g]), .f_o(f_v[g])
        );
    end

    pll_pick #(.FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W)) u_pick (
        .m_base_i(m_v[0]), .n_base_i(n_v[0]), .f_base_i(f_v[0]),
        .m_dbl_i(m_v[1]),  .n_dbl_i(n_v[1]),  .f_dbl_i(f_v[1]),
        .dbl_o(dbl_sel), .found_o(found), .m_o(m_out), .n_o(n_out),
        .f_o(freq_khz), .div_o(div_field)
    );

    assign busy = busy_v[0];
    assign done = done_v[0];
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
    parameter int unsigned FREQ_W = 22,
    parameter int unsigned M_W    = 4,
    parameter int unsigned N_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [FREQ_W-1:0] target_khz,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              dbl_sel,
    input logic [M_W-1:0]    m_out,
    input logic [N_W-1:0]    n_out,
    input logic [FREQ_W-1:0] freq_khz,
    input logic [M_W-1:0]    div_field
);
    logic [FREQ_W-1:0] tgt_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)             tgt_seen <= '0;
        else if (start && !busy) tgt_seen <= target_khz;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (freq_khz < tgt_seen)); // R3
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (m_out == '0 && n_out == '0 && freq_khz == '0
                              && div_field == '0 && !dbl_sel)); // R6
    AST_DIV_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (div_field == m_out - 1'b1)); // R7
    AST_FACTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (m_out >= 1 && m_out <= 15 && n_out >= 9 && n_out <= 127)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable(freq_khz)); // R10
endmodule

bind pll_factor_search pll_search_chk #(.FREQ_W(FREQ_W), .M_W(M_W), .N_W(N_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .busy(busy), .done(done), .found(found), .dbl_sel(dbl_sel),
    .m_out(m_out), .n_out(n_out), .freq_khz(freq_khz), .div_field(div_field)
);

// File: tb/sim_pll_factor_search.sv
module sim_pll_factor_search;
    localparam int DONE_EDGE = 1 + 15 * 119;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] ref_khz = '0;
    logic [21:0] target_khz = '0;
    logic        busy, done, found, dbl_sel;
    logic [3:0]  m_out, div_field;
    logic [6:0]  n_out;
    logic [21:0] freq_khz;

    int errors = 0;
    int checks = 0;
    int edges = 0;

    always #10 clk = ~clk;
    always @(posedge clk) edges++;

    pll_factor_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz),
        .target_khz(target_khz), .busy(busy), .done(done), .found(found),
        .dbl_sel(dbl_sel), .m_out(m_out), .n_out(n_out), .freq_khz(freq_khz),
        .div_field(div_field)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait (edges > 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one search as the requirements describe it (R2, R3, R4)
    function automatic void one_search(input longint r, input longint t,
                                       output int bm, output int bn, output longint bf);
        longint best = 1000000;
        bm = 0; bn = 0; bf = 0;
        for (int m = 1; m <= 15; m++)
            for (int n = 9; n <= 127; n++) begin
                longint c = (n * r) / m;
                if (t - c > 0 && t - c < best) begin
                    best = t - c; bm = m; bn = n; bf = c;
                end
            end
    endfunction

    function automatic void model(input longint r, input longint t, output int em, output int en,
                                  output longint ef, output int ed, output int efd);
        int m0, n0, m1, n1;
        longint f0, f1;
        one_search(r, t, m0, n0, f0);
        one_search(2 * r, t, m1, n1, f1);
        if (f1 > f0) begin em = m1; en = n1; ef = f1; ed = 1; end  // R5
        else         begin em = m0; en = n0; ef = f0; ed = 0; end
        efd = (em != 0) ? 1 : 0;
    endfunction

    task automatic check_outputs(input string tag, input longint r, input longint t);
        int em, en, ed, efd;
        longint ef;
        model(r, t, em, en, ef, ed, efd);
        chk({tag, " found"}, found, efd);
        chk({tag, " m"}, m_out, em);
        chk({tag, " n"}, n_out, en);
        chk({tag, " freq"}, freq_khz, ef);
        chk({tag, " dbl"}, dbl_sel, ed);
        chk({tag, " div"}, div_field, efd ? em - 1 : 0);
    endtask

    // start, then count rising edges; done must appear after edge DONE_EDGE (R8)
    task automatic run(input int r, input int t, input bit poke);
        int cyc;
        @(negedge clk);
        ref_khz = 13'(r); target_khz = 22'(t); start = 1'b1;
        @(posedge clk); cyc = 1;
        @(negedge clk); start = 1'b0;
        chk("R8 busy after start", busy, 1);
        while (!done && cyc < DONE_EDGE + 20) begin
            if (poke && cyc == 100) begin
                // R9: start while busy with a different target is ignored
                target_khz = 22'(t + 5000); start = 1'b1;
            end
            if (poke && cyc == 101) begin start = 1'b0; target_khz = 22'(t); end
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        chk(poke ? "R9 done edge" : "R8 done edge", cyc, DONE_EDGE);
        chk("R8 busy low at done", busy, 0);
    endtask

    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{3000, 27000,   1},   // R2 R3 exact match present, must be skipped
        '{3000, 148500,  1},   // R2
        '{3000, 65000,   1},   // R5
        '{3000, 1801,    1},   // R2 smallest base candidate
        '{3000, 1800,    0},   // R6 R3 nothing strictly below
        '{3000, 1761999, 1},   // R4 gap just below limit
        '{3000, 1762000, 0},   // R4 gap equal to limit
        '{2500, 74250,   1}    // R7
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 found", found, 0);
        chk("R1 dbl", dbl_sel, 0);
        chk("R1 m", m_out, 0);
        chk("R1 freq", freq_khz, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][0], VEC[i][1], 1'b0);
            chk($sformatf("R6 vec%0d found", i), found, VEC[i][2]);
            check_outputs($sformatf("R2 R5 R7 vec%0d", i), VEC[i][0], VEC[i][1]);
            @(negedge clk);
            chk("R8 done single pulse", done, 0);
        end

        // R3 direct: 27000 is reachable exactly but must not be reported
        run(3000, 27000, 1'b0);
        chk("R3 freq below target", (freq_khz < 27000) ? 1 : 0, 1);

        // R10 hold after done while inputs change
        target_khz = 22'd9999; ref_khz = 13'd100;
        repeat (6) @(negedge clk);
        check_outputs("R10 hold", 3000, 27000);

        // R9 start ignored while busy
        run(3000, 100000, 1'b1);
        check_outputs("R9 ignored start", 3000, 100000);

        summary();
    end
endmodule